// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block sits between a small 8-bit host bus and a serial transmitter/receiver pair. The host selects the block with a chip select, gives a 2-bit address and a write flag, and either writes a byte or collects a byte that the block returns. The block turns each access into the right action:
- a one-clock load strobe with the byte for the transmitter;
- a one-clock read strobe that tells the receiver its byte was taken;
- an update of the control byte;
- a returned copy of the receive byte, the status byte or the control byte.

The control byte holds two interrupt enables and a baud-rate select. The serializer and the baud generator are elsewhere and read that select from the `ctrl` output.

The block also drives a single interrupt line. The line is built from three flags that the serial logic reports: receive full, overrun and transmit empty. Each flag is gated by its enable bit. A tri-state bus driver is modelled as a data output plus an output-enable. Outside the one cycle in which read data is returned, the enable is low and the data output is zero.

One access controller decides when a bus cycle takes effect. Its states are IDLE, ACCESS and HOLD:
- IDLE goes to ACCESS when chip select is sampled high. That same edge captures the operation, the write byte and the value to return, and applies any control write.
- ACCESS lasts exactly one clock. The strobes and the read enable come out during this clock.
- From ACCESS the controller goes to HOLD if chip select is still high, or back to IDLE if it is low.
- HOLD returns to IDLE once chip select falls.

So a select held high for several clocks counts as a single access. Read data and strobes appear in the cycle after the edge that samples chip select.

Top module: `uart_host_regs`

## Requirements
- R1: A read at address 00 returns `rx_data`, as sampled at the edge that sees `cs`, on `rdata` with `rdata_oe` high for one clock in the following cycle. `rx_read` is high for exactly that one clock.
- R2: A write at address 00 raises `tx_load` for exactly one clock in the cycle after the sampling edge, with `tx_data` equal to the written byte.
- R3: A read at address 01 returns the status byte. Bit 7 is transmit-empty, bit 6 is receive-full, bit 0 is overrun, and bits 5..1 are zero.
- R4: A write at address 01 has no effect. No strobe fires, `rdata_oe` stays low and `ctrl` is unchanged.
- R5: A write at address 10 or 11 loads `ctrl` from the bus at the sampling edge. Bit 7 is the transmit interrupt enable, bit 6 is the receive interrupt enable, bits 2..0 are the baud select, and bits 5..3 always read zero. A read at 10 or 11 returns `ctrl`. No other access changes `ctrl`.
- R6: `rdata_oe` is high only in the single cycle that returns read data. At all other times it is low and `rdata` is zero.
- R7: `irq` is high exactly when (bit 6 of `ctrl` and (receive-full or overrun)) or (bit 7 of `ctrl` and transmit-empty). It follows the flags in the same cycle.
- R8: While `cs` is low, the block does nothing. A `cs` held high for several clocks produces exactly one access.
- R9: Reset clears `ctrl` to zero, so both enables are off and the baud select is 000. It also holds `irq`, `rdata_oe`, `tx_load` and `rx_read` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select; an access needs it high |
| addr | input | 2 | Register address |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | DATA_W | Byte from the host |
| rx_data | input | DATA_W | Byte held by the receiver |
| rx_full | input | 1 | Receiver holds an unread byte |
| tx_empty | input | 1 | Transmit holding register is empty |
| overrun | input | 1 | Receiver lost a byte |
| rdata | output | DATA_W | Byte returned to the host (zero when not driving) |
| rdata_oe | output | 1 | Output-enable standing in for the tri-state driver |
| tx_load | output | 1 | One-clock load strobe to the transmitter |
| tx_data | output | DATA_W | Byte for the transmitter |
| rx_read | output | 1 | One-clock strobe: receive byte taken |
| ctrl | output | DATA_W | Control byte contents |
| irq | output | 1 | Combined interrupt |

## Verification
If the access controller stays in ACCESS, or leaves HOLD while chip select is still high, the ports show a repeated strobe or an output-enable that lasts too long. This shows on the very next clock, so the bench checks every cycle for bus activity that was not expected. A wrong decoded operation shows in the cycle after the sampling edge as the wrong strobe or the wrong returned byte. A corrupted control byte shows on `ctrl` right after the edge, and on `irq` as soon as a flag changes.

// File: rtl/uhr_pkg.sv
package uhr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_HOLD   = 2'd2
    } acc_state_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_RX_READ    = 3'd1,
        OP_TX_WRITE   = 3'd2,
        OP_STAT_READ  = 3'd3,
        OP_STAT_NULL  = 3'd4,
        OP_CTRL_READ  = 3'd5,
        OP_CTRL_WRITE = 3'd6
    } bus_op_e;

endpackage

// File: rtl/uhr_decode.sv
module uhr_decode
    import uhr_pkg::*;
(
    input  logic       cs,
    input  logic [1:0] addr,
    input  logic       we,
    output bus_op_e    op
);

    always_comb begin
        op = OP_NONE;
        if (cs) begin
            unique casez (addr)
                2'b00: op = we ? OP_TX_WRITE  : OP_RX_READ;
                2'b01: op = we ? OP_STAT_NULL : OP_STAT_READ;
                2'b1?: op = we ? OP_CTRL_WRITE : OP_CTRL_READ;
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/uhr_ctrl_reg.sv
module uhr_ctrl_reg #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl
);

    localparam int TIE_BIT = DATA_W - 1;
    localparam int RIE_BIT = DATA_W - 2;

    logic [DATA_W-1:0] keep_mask;

    // Only the two enables and the baud select hold state; the rest read zero.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i == TIE_BIT || i == RIE_BIT || i < SEL_W) begin : g_keep
            assign keep_mask[i] = 1'b1;
        end else begin : g_zero
            assign keep_mask[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (load) begin
            ctrl <= wdata & keep_mask;
        end
    end

endmodule

// File: rtl/uhr_status_irq.sv
module uhr_status_irq #(
    parameter int DATA_W = 8
) (
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              overrun,
    input  logic              tie,
    input  logic              rie,
    output logic [DATA_W-1:0] status,
    output logic              irq
);

    always_comb begin
        status             = '0;
        status[DATA_W-1]   = tx_empty;
        status[DATA_W-2]   = rx_full;
        status[0]          = overrun;
    end

    logic rx_src;
    logic tx_src;

    assign rx_src = rie & (rx_full | overrun);
    assign tx_src = tie & tx_empty;
    assign irq    = rx_src | tx_src;

endmodule

// File: rtl/uhr_fsm.sv
module uhr_fsm
    import uhr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  bus_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] ctrl,
    output logic              ctrl_load,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_read
);

    acc_state_e        state_q;
    acc_state_e        state_d;
    bus_op_e           op_q;
    logic [DATA_W-1:0] rd_buf;
    logic [DATA_W-1:0] wr_buf;
    logic              start;
    logic [DATA_W-1:0] rd_sel;

    assign start = (state_q == ST_IDLE) && (op != OP_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACCESS;
            ST_ACCESS: state_d = cs ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (!cs) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (op)
            OP_RX_READ:   rd_sel = rx_data;
            OP_STAT_READ: rd_sel = status;
            OP_CTRL_READ: rd_sel = ctrl;
            default:      rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            rd_buf <= '0;
            wr_buf <= '0;
        end else if (start) begin
            op_q   <= op;
            rd_buf <= rd_sel;
            wr_buf <= wdata;
        end
    end

    assign ctrl_load = start && (op == OP_CTRL_WRITE);

    always_comb begin
        rdata_oe = 1'b0;
        rdata    = '0;
        tx_load  = 1'b0;
        tx_data  = wr_buf;
        rx_read  = 1'b0;
        unique case (state_q)
            ST_ACCESS: begin
                rdata_oe = (op_q == OP_RX_READ) || (op_q == OP_STAT_READ) ||
                           (op_q == OP_CTRL_READ);
                rdata    = rdata_oe ? rd_buf : '0;
                tx_load  = (op_q == OP_TX_WRITE);
                rx_read  = (op_q == OP_RX_READ);
            end
            ST_IDLE, ST_HOLD: begin
                rdata_oe = 1'b0;
            end
            default: begin
                rdata_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uhr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [1:0]        addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              overrun,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_read,
    output logic [DATA_W-1:0] ctrl,
    output logic              irq
);

    bus_op_e           op;
    logic              ctrl_load;
    logic [DATA_W-1:0] status;

    uhr_decode u_decode (
        .cs   (cs),
        .addr (addr),
        .we   (we),
        .op   (op)
    );

    uhr_ctrl_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctrl_load),
        .wdata (wdata),
        .ctrl  (ctrl)
    );

    uhr_status_irq #(.DATA_W(DATA_W)) u_stat (
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .overrun  (overrun),
        .tie      (ctrl[DATA_W-1]),
        .rie      (ctrl[DATA_W-2]),
        .status   (status),
        .irq      (irq)
    );

    uhr_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .op        (op),
        .wdata     (wdata),
        .rx_data   (rx_data),
        .status    (status),
        .ctrl      (ctrl),
        .ctrl_load (ctrl_load),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .rx_read   (rx_read)
    );

endmodule

// File: rtl/uhr_chk.sv
module uhr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic [1:0]        addr,
    input logic              we,
    input logic              tx_empty,
    input logic              rdata_oe,
    input logic              tx_load,
    input logic              rx_read,
    input logic [DATA_W-1:0] ctrl,
    input logic              irq
);

    // R1
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |=> !rx_read);

    // R1
    rx_strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |-> rdata_oe);

    // R2
    tx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R2
    tx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(cs && we && addr == 2'b00));

    // R6
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(cs && !we));

    // R6
    oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |=> !rdata_oe);

    // R5
    ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(cs && we && addr[1]));

    // R7
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[DATA_W-1] && tx_empty) |-> irq);

endmodule

bind uart_host_regs uhr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .addr     (addr),
    .we       (we),
    .tx_empty (tx_empty),
    .rdata_oe (rdata_oe),
    .tx_load  (tx_load),
    .rx_read  (rx_read),
    .ctrl     (ctrl),
    .irq      (irq)
);

// File: tb/sim_uart_host_regs.sv
`timescale 1ns/1ps
module sim_uart_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rx_data = 8'h00;
    logic       rx_full = 1'b0;
    logic       tx_empty = 1'b0;
    logic       overrun = 1'b0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       tx_load;
    logic [7:0] tx_data;
    logic       rx_read;
    logic [7:0] ctrl;
    logic       irq;

    always #2 clk = ~clk;

    uart_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .we(we),
        .wdata(wdata), .rx_data(rx_data), .rx_full(rx_full),
        .tx_empty(tx_empty), .overrun(overrun), .rdata(rdata),
        .rdata_oe(rdata_oe), .tx_load(tx_load), .tx_data(tx_data),
        .rx_read(rx_read), .ctrl(ctrl), .irq(irq)
    );

    typedef struct {
        logic       oe;
        logic [7:0] rd;
        logic       ld;
        logic [7:0] td;
        logic       rr;
        int         due;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_word(input logic te, input logic rf, input logic ov);
        return {te, rf, 5'b00000, ov};
    endfunction

    // Monitor: compares due items, otherwise the bus must be quiet (R6, R8)
    always @(negedge clk) begin
        if (!done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "rdata_oe", {31'd0, rdata_oe}, {31'd0, e.oe});
                if (e.oe) chk(e.req, "rdata", {24'd0, rdata}, {24'd0, e.rd});
                chk(e.req, "tx_load", {31'd0, tx_load}, {31'd0, e.ld});
                if (e.ld) chk(e.req, "tx_data", {24'd0, tx_data}, {24'd0, e.td});
                chk(e.req, "rx_read", {31'd0, rx_read}, {31'd0, e.rr});
            end else begin
                chk("R6/R8 idle", "oe,ld,rr", {29'd0, rdata_oe, tx_load, rx_read}, 32'd0);
                chk("R6 idle", "rdata", {24'd0, rdata}, 32'd0);
            end
        end
    end

    // Driver: called at a negedge, returns at a negedge with the block idle
    task automatic access(input logic w, input logic [1:0] a, input logic [7:0] d,
                          input int hold, input logic e_oe, input logic [7:0] e_rd,
                          input logic e_ld, input logic e_rr, input string req);
        exp_t e;
        cs = 1'b1; we = w; addr = a; wdata = d;
        e.oe = e_oe; e.rd = e_rd; e.ld = e_ld; e.td = d; e.rr = e_rr;
        e.due = cyc + 1; e.req = req;
        q.push_back(e);
        repeat (hold) @(negedge clk);
        cs = 1'b0; we = 1'b0; wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic set_flags(input logic rf, input logic te, input logic ov);
        rx_full = rf; tx_empty = te; overrun = ov;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        set_flags(1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9", "ctrl in reset", {24'd0, ctrl}, 32'd0);
        chk("R9", "irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "ctrl after reset", {24'd0, ctrl}, 32'd0);
        chk("R7", "irq with enables off", {31'd0, irq}, 32'd0);

        // R1: receive byte read
        rx_data = 8'hA5;
        access(1'b0, 2'b00, 8'h00, 1, 1'b1, 8'hA5, 1'b0, 1'b1, "R1 read rx");
        rx_data = 8'h5A;
        access(1'b0, 2'b00, 8'h00, 1, 1'b1, 8'h5A, 1'b0, 1'b1, "R1 read rx b2b");

        // R2: transmit byte write
        access(1'b1, 2'b00, 8'h3C, 1, 1'b0, 8'h00, 1'b1, 1'b0, "R2 write tx");
        access(1'b1, 2'b00, 8'hC3, 1, 1'b0, 8'h00, 1'b1, 1'b0, "R2 write tx b2b");

        // R3: status word
        set_flags(1'b0, 1'b1, 1'b1);
        access(1'b0, 2'b01, 8'h00, 1, 1'b1, stat_word(1'b1, 1'b0, 1'b1), 1'b0, 1'b0, "R3 status te,ov");
        set_flags(1'b1, 1'b0, 1'b0);
        access(1'b0, 2'b01, 8'h00, 1, 1'b1, stat_word(1'b0, 1'b1, 1'b0), 1'b0, 1'b0, "R3 status rf");

        // R4: write to status address does nothing
        access(1'b1, 2'b01, 8'hFF, 1, 1'b0, 8'h00, 1'b0, 1'b0, "R4 status write");
        chk("R4", "ctrl unchanged", {24'd0, ctrl}, 32'd0);

        // R5: control write and read, reserved bits zero
        access(1'b1, 2'b10, 8'hFF, 1, 1'b0, 8'h00, 1'b0, 1'b0, "R5 ctrl write");
        chk("R5", "ctrl masked", {24'd0, ctrl}, 32'hC7);
        access(1'b0, 2'b11, 8'h00, 1, 1'b1, 8'hC7, 1'b0, 1'b0, "R5 ctrl read");
        access(1'b1, 2'b11, 8'h45, 1, 1'b0, 8'h00, 1'b0, 1'b0, "R5 ctrl write alt");
        chk("R5", "ctrl alt addr", {24'd0, ctrl}, 32'h45);

        // R7: interrupt combinations, RIE=1 TIE=0
        set_flags(1'b0, 1'b0, 1'b0);
        chk("R7", "irq no flags", {31'd0, irq}, 32'd0);
        set_flags(1'b1, 1'b0, 1'b0);
        chk("R7", "irq rx full", {31'd0, irq}, 32'd1);
        set_flags(1'b0, 1'b0, 1'b1);
        chk("R7", "irq overrun", {31'd0, irq}, 32'd1);
        set_flags(1'b0, 1'b1, 1'b0);
        chk("R7", "irq tx empty gated", {31'd0, irq}, 32'd0);
        access(1'b1, 2'b10, 8'h80, 1, 1'b0, 8'h00, 1'b0, 1'b0, "R5 ctrl tie only");
        chk("R7", "irq tx empty enabled", {31'd0, irq}, 32'd1);
        set_flags(1'b1, 1'b0, 1'b1);
        chk("R7", "irq rx gated", {31'd0, irq}, 32'd0);

        // R8: cs low does nothing; held cs gives one access
        cs = 1'b0; we = 1'b1; addr = 2'b10; wdata = 8'h00;
        repeat (4) @(negedge clk);
        we = 1'b0;
        chk("R8", "ctrl with cs low", {24'd0, ctrl}, 32'h80);
        rx_data = 8'h77;
        access(1'b0, 2'b00, 8'h00, 3, 1'b1, 8'h77, 1'b0, 1'b1, "R8 held read");
        access(1'b1, 2'b00, 8'h19, 4, 1'b0, 8'h00, 1'b1, 1'b0, "R8 held write");
        access(1'b1, 2'b01, 8'hAA, 2, 1'b0, 8'h00, 1'b0, 1'b0, "R4 held status write");
        chk("R4", "ctrl after status write", {24'd0, ctrl}, 32'h80);

        repeat (3) @(negedge clk);
        chk("R1", "queue drained", q.size(), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule